// File: doc/BRIEF.md
# Bus Arbitration Handshake Controller

This block decides who owns a single shared bus that carries one master at a time: either the local side (processor and internal DMA engines) or an external device. External requesters always win over the local side. They take the bus through a three-wire handshake: the external device raises a request, the controller answers with a grant, and the device raises an acknowledge for as long as it keeps the bus. The local side gets the bus back when that acknowledge drops.

The grant is never issued in the middle of a local operand. An operand that is wider than the port is moved in several bus beats, and the grant waits for the beat that ends the operand. The grant also waits while a locked read-modify-write sequence is in progress. A separate registered bus-clear output asks external masters to withdraw their request. It is raised when an internal DMA or refresh engine wants the bus, or when a pending interrupt level is above a programmable threshold.

The state machine has three states:
- `ARB_LOCAL`: the local side owns the bus.
- `ARB_OFFER`: the grant is driven and the controller waits for the acknowledge.
- `ARB_EXTERN`: an external master owns the bus.

Transitions:
- `ARB_LOCAL` to `ARB_OFFER`: a request is present at a safe point and no lock is set.
- `ARB_OFFER` to `ARB_EXTERN`: the acknowledge is seen.
- `ARB_OFFER` to `ARB_LOCAL`: the request and the acknowledge are both low (the request was withdrawn).
- `ARB_EXTERN` to `ARB_LOCAL`: the acknowledge drops.

Top module: `busarb_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `local_bus_en` is 1 and `bus_grant` and `bus_clr` are 0. A reset asserted while a grant is pending returns the bus to the local side at once.
- R2: `bus_grant` and `local_bus_en` are never both 1. When the local side is idle (`xfer_busy`=0) and no lock is set, a request sampled at a clock edge gives `bus_grant`=1 and `local_bus_en`=0 after that edge.
- R3: While `xfer_busy`=1, the grant is held back until the edge where `beat_done`=1 on the last beat of the operand. Sizes are coded as log2 of bytes (0=1, 1=2, 2=4 bytes). The operand takes 2^(op_size-port_size) beats when op_size > port_size, and 1 beat otherwise.
- R4: While `rmw_lock`=1, no grant is issued. The grant follows the first edge at which the request is sampled with the lock low.
- R5: When the acknowledge is sampled high during a grant, `bus_grant` is 0 after that edge. `local_bus_en` stays 0 for as long as the acknowledge stays high.
- R6: When the acknowledge is sampled low while an external master owns the bus, `local_bus_en` is 1 after that edge.
- R7: When the request and the acknowledge are both sampled low while the grant is driven, the grant drops and `local_bus_en` is 1 after that edge.
- R8: `bus_clr` is 1 one cycle after any bit of `int_mst_req` is high. The bits are: bit 0 block DMA, bit 1 serial DMA, bit 2 memory refresh.
- R9: `bus_clr` is 1 one cycle after `irq_lvl` (0..7) is strictly greater than `irq_thr`. It is 0 when they are equal and no internal request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 1 | Bus request from an external master |
| ext_ack | input | 1 | Grant acknowledge; held high while the external master owns the bus |
| xfer_busy | input | 1 | A local operand transfer is in progress |
| beat_done | input | 1 | One bus beat of the local transfer completes in this cycle |
| op_size | input | 2 | Operand size, log2 of bytes |
| port_size | input | 2 | Port width, log2 of bytes |
| rmw_lock | input | 1 | Locked read-modify-write sequence in progress |
| int_mst_req | input | N_MST | Bus requests from the internal masters |
| irq_lvl | input | LVL_W | Level of the pending interrupt |
| irq_thr | input | LVL_W | Programmable interrupt threshold |
| bus_grant | output | 1 | Bus grant to the external master |
| bus_clr | output | 1 | Request for external masters to release the bus |
| local_bus_en | output | 1 | The local side may start bus cycles |

## Verification
The assertions check these rules on every cycle:
- `bus_grant` and `local_bus_en` are never both high.
- A rising grant always follows a sampled request with no lock set.
- An acknowledge during a grant removes the grant on the next cycle, and the local side stays off the bus while the acknowledge is held.
- A withdrawn request returns the bus to the local side.
- `bus_clr` follows both of its causes, and stays low when neither is present.

Only the bench scenarios can show that the grant waits for the exact last beat, with the beat count taken from the operand and port sizes. The same holds for where the grant lands after a lock is released, and for the equal-level boundary of the interrupt comparison.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    typedef enum logic [1:0] {
        ARB_LOCAL  = 2'd0,
        ARB_OFFER  = 2'd1,
        ARB_EXTERN = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_boundary.sv
// Tracks the beats of a local operand and flags the edge where a grant is safe.
module arb_boundary #(
    parameter int SZ_W  = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_busy,
    input  logic             beat_done,
    input  logic [SZ_W-1:0]  op_size,
    input  logic [SZ_W-1:0]  port_size,
    output logic             safe_pt
);
    logic [SZ_W-1:0]  span;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] beat_cnt;
    logic             last_beat;

    always_comb begin
        span      = (op_size > port_size) ? (op_size - port_size) : '0;
        last_idx  = CNT_W'((32'd1 << span) - 32'd1);
        last_beat = (beat_cnt == last_idx);
        safe_pt   = !xfer_busy || (beat_done && last_beat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (!xfer_busy) begin
            beat_cnt <= '0;
        end else if (beat_done) begin
            beat_cnt <= last_beat ? '0 : beat_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/arb_clear.sv
// Registered bus-clear request from internal masters or an interrupt above threshold.
module arb_clear #(
    parameter int N_MST = 3,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] int_mst_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0] irq_thr,
    output logic             bus_clr
);
    logic want_clr;

    always_comb begin
        want_clr = (|int_mst_req) || (irq_lvl > irq_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_clr <= 1'b0;
        end else begin
            bus_clr <= want_clr;
        end
    end
endmodule

// File: rtl/arb_fsm.sv
// Request / grant / acknowledge ownership state machine.
module arb_fsm
    import busarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic ext_ack,
    input  logic safe_pt,
    input  logic rmw_lock,
    output logic bus_grant,
    output logic local_bus_en
);
    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_LOCAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_LOCAL: begin
                if (ext_req && safe_pt && !rmw_lock) begin
                    state_d = ARB_OFFER;
                end
            end
            ARB_OFFER: begin
                if (ext_ack) begin
                    state_d = ARB_EXTERN;
                end else if (!ext_req) begin
                    state_d = ARB_LOCAL;
                end
            end
            ARB_EXTERN: begin
                if (!ext_ack) begin
                    state_d = ARB_LOCAL;
                end
            end
            default: state_d = ARB_LOCAL;
        endcase
    end

    always_comb begin
        bus_grant    = (state_q == ARB_OFFER);
        local_bus_en = (state_q == ARB_LOCAL);
    end
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl #(
    parameter int N_MST = 3,
    parameter int LVL_W = 3,
    parameter int SZ_W  = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_req,
    input  logic             ext_ack,
    input  logic             xfer_busy,
    input  logic             beat_done,
    input  logic [SZ_W-1:0]  op_size,
    input  logic [SZ_W-1:0]  port_size,
    input  logic             rmw_lock,
    input  logic [N_MST-1:0] int_mst_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0] irq_thr,
    output logic             bus_grant,
    output logic             bus_clr,
    output logic             local_bus_en
);
    logic safe_pt;

    arb_boundary #(.SZ_W(SZ_W), .CNT_W(CNT_W)) u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_busy (xfer_busy),
        .beat_done (beat_done),
        .op_size   (op_size),
        .port_size (port_size),
        .safe_pt   (safe_pt)
    );

    arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req      (ext_req),
        .ext_ack      (ext_ack),
        .safe_pt      (safe_pt),
        .rmw_lock     (rmw_lock),
        .bus_grant    (bus_grant),
        .local_bus_en (local_bus_en)
    );

    arb_clear #(.N_MST(N_MST), .LVL_W(LVL_W)) u_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .int_mst_req (int_mst_req),
        .irq_lvl     (irq_lvl),
        .irq_thr     (irq_thr),
        .bus_clr     (bus_clr)
    );
endmodule

// File: rtl/busarb_ctrl_chk.sv
module busarb_ctrl_chk #(
    parameter int N_MST = 3,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_req,
    input logic             ext_ack,
    input logic             rmw_lock,
    input logic [N_MST-1:0] int_mst_req,
    input logic [LVL_W-1:0] irq_lvl,
    input logic [LVL_W-1:0] irq_thr,
    input logic             bus_grant,
    input logic             bus_clr,
    input logic             local_bus_en
);
    // R2
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_grant && local_bus_en));

    // R2 R4
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> ($past(ext_req) && !$past(rmw_lock)));

    // R5
    ack_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && ext_ack) |=> !bus_grant);

    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_bus_en && ext_ack) |=> !local_bus_en);

    // R7
    withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !ext_req && !ext_ack) |=> (!bus_grant && local_bus_en));

    // R8
    int_mst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_mst_req) |=> bus_clr);

    // R9
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl > irq_thr) |=> bus_clr);

    // R8 R9
    no_cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|int_mst_req) && !(irq_lvl > irq_thr)) |=> !bus_clr);
endmodule

bind busarb_ctrl busarb_ctrl_chk #(.N_MST(N_MST), .LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_req      (ext_req),
    .ext_ack      (ext_ack),
    .rmw_lock     (rmw_lock),
    .int_mst_req  (int_mst_req),
    .irq_lvl      (irq_lvl),
    .irq_thr      (irq_thr),
    .bus_grant    (bus_grant),
    .bus_clr      (bus_clr),
    .local_bus_en (local_bus_en)
);

// File: tb/busarb_ctrl_test.sv
module busarb_ctrl_test;
    localparam int PERIOD = 10;
    localparam int NV     = 28;

    typedef struct packed {
        logic       req;
        logic       ack;
        logic       busy;
        logic       beat;
        logic [1:0] op;
        logic [1:0] port;
        logic       rmw;
        logic [2:0] imr;
        logic [2:0] lvl;
        logic [2:0] thr;
        logic       eg;
        logic       el;
        logic       ec;
    } vec_t;

    // Columns: req ack busy beat op port rmw imr lvl thr | grant local clr
    localparam vec_t TBL [NV] = '{
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 0  R2 idle
        '{1,0,0,0,0,0,0,0,0,0, 1,0,0}, // 1  R2 grant when idle
        '{1,1,0,0,0,0,0,0,0,0, 0,0,0}, // 2  R5 ack drops grant
        '{0,1,0,0,0,0,0,0,0,0, 0,0,0}, // 3  R5 ack held
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 4  R6 ack released
        '{1,0,1,0,2,0,0,0,0,0, 0,1,0}, // 5  R3 busy, no beat
        '{1,0,1,1,2,0,0,0,0,0, 0,1,0}, // 6  R3 beat 1 of 4
        '{1,0,1,1,2,0,0,0,0,0, 0,1,0}, // 7  R3 beat 2 of 4
        '{1,0,1,1,2,0,0,0,0,0, 0,1,0}, // 8  R3 beat 3 of 4
        '{1,0,1,0,2,0,0,0,0,0, 0,1,0}, // 9  R3 wait state
        '{1,0,1,1,2,0,0,0,0,0, 1,0,0}, // 10 R3 fourth beat ends operand
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 11 R7 withdrawn
        '{1,0,0,0,0,0,1,0,0,0, 0,1,0}, // 12 R4 locked
        '{1,0,0,0,0,0,1,0,0,0, 0,1,0}, // 13 R4 still locked
        '{1,0,0,0,0,0,0,0,0,0, 1,0,0}, // 14 R4 lock released
        '{1,1,0,0,0,0,0,0,0,0, 0,0,0}, // 15 R5
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 16 R6
        '{1,0,1,1,1,1,0,0,0,0, 1,0,0}, // 17 R3 equal sizes, one beat
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 18 R7
        '{0,0,0,0,0,0,0,4,0,0, 0,1,1}, // 19 R8 refresh
        '{0,0,0,0,0,0,0,1,0,0, 0,1,1}, // 20 R8 block DMA
        '{0,0,0,0,0,0,0,0,5,5, 0,1,0}, // 21 R9 equal level
        '{0,0,0,0,0,0,0,0,6,5, 0,1,1}, // 22 R9 above
        '{0,0,0,0,0,0,0,0,7,7, 0,1,0}, // 23 R9 top equal
        '{0,0,0,0,0,0,0,0,1,0, 0,1,1}, // 24 R9 zero threshold
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}, // 25 R8 R9 no cause
        '{1,0,1,1,0,2,0,0,0,0, 1,0,0}, // 26 R3 narrow operand, wide port
        '{0,0,0,0,0,0,0,0,0,0, 0,1,0}  // 27 R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req, ext_ack, xfer_busy, beat_done, rmw_lock;
    logic [1:0] op_size, port_size;
    logic [2:0] int_mst_req, irq_lvl, irq_thr;
    logic       bus_grant, bus_clr, local_bus_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    busarb_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req      (ext_req),
        .ext_ack      (ext_ack),
        .xfer_busy    (xfer_busy),
        .beat_done    (beat_done),
        .op_size      (op_size),
        .port_size    (port_size),
        .rmw_lock     (rmw_lock),
        .int_mst_req  (int_mst_req),
        .irq_lvl      (irq_lvl),
        .irq_thr      (irq_thr),
        .bus_grant    (bus_grant),
        .bus_clr      (bus_clr),
        .local_bus_en (local_bus_en)
    );

    task automatic drive(input vec_t v);
        ext_req     = v.req;
        ext_ack     = v.ack;
        xfer_busy   = v.busy;
        beat_done   = v.beat;
        op_size     = v.op;
        port_size   = v.port;
        rmw_lock    = v.rmw;
        int_mst_req = v.imr;
        irq_lvl     = v.lvl;
        irq_thr     = v.thr;
    endtask

    task automatic check3(input string tag, input logic eg, input logic el, input logic ec);
        n_chk++;
        if (bus_grant !== eg || local_bus_en !== el || bus_clr !== ec) begin
            n_fail++;
            $display("FAIL %s: got grant=%b local=%b clr=%b, expected grant=%b local=%b clr=%b",
                     tag, bus_grant, local_bus_en, bus_clr, eg, el, ec);
        end
    endtask

    initial begin
        drive('0);
        repeat (2) @(negedge clk);
        // R1: outputs held in reset
        check3("R1 in reset", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 after reset", 1'b0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check3($sformatf("table row %0d", i), TBL[i].eg, TBL[i].el, TBL[i].ec);
        end

        // R2 / R1: grant pending, then reset returns the bus at once
        drive('0);
        ext_req = 1'b1;
        @(negedge clk);
        check3("R2 grant before reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check3("R1 reset during grant", 1'b0, 1'b1, 1'b0);
        ext_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: serial DMA bit while an external master owns the bus
        ext_req = 1'b1;
        @(negedge clk);
        ext_ack = 1'b1;
        @(negedge clk);
        int_mst_req = 3'b010;
        @(negedge clk);
        check3("R8 clear while external owns", 1'b0, 1'b0, 1'b1);
        ext_req = 1'b0;
        ext_ack = 1'b0;
        int_mst_req = 3'b000;
        @(negedge clk);
        check3("R6 return after clear", 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule